// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block connects a processor bus to two 8-bit general-purpose peripheral ports, called A and B. Each port holds three registers: a direction register, an output register and a control register. Software picks the direction of each pin one bit at a time. It drives output pins from the output register and reads the pins back through the same bus. Each port also drives one auxiliary control line, which the port's control register programs.

Only two address bits reach the block, so each port has two locations. One location always holds the control register. The other location is shared by the direction register and the output register. Bit 2 of that port's control register picks which of the two the shared location reaches. Software normally clears the bit, loads the direction, then sets the bit to move data.

A write takes effect on the clock edge where all of the following hold: the chip is selected, the read/write line is low and the enable strobe is high. A read drives the addressed register onto the read-data bus. No edge is needed for a read. The pins are not tri-state pads. Each pin has a separate output value, output enable and input value.

Top module: `dual_port_pio`

## Requirements
- R1: The chip is selected only when `cs_a` and `cs_b` are high and `cs_n` is low at the same time. When it is not selected, writes change no register and `rdata` is zero.
- R2: `rsel[1]` picks the port (0 = A, 1 = B). `rsel[0]` = 1 addresses that port's control register.
- R3: With `rsel[0]` = 0, control bit 2 of the addressed port routes the access. A cleared bit reaches the direction register. A set bit reaches the output register.
- R4: A register is loaded only on a rising clock edge where the chip is selected, `rw` is 0 and `stb` is 1. If `stb` is low, or if `rw` is high, no register changes.
- R5: While the chip is selected and `rw` is 1, `rdata` shows the addressed register in the same cycle. Otherwise `rdata` is zero.
- R6: A read of the output-register location returns, for each bit, the input pin if that direction bit is 0, or the output-register bit if that direction bit is 1.
- R7: Each pin's output enable equals its direction-register bit, where 1 means output. Its output value equals the output-register bit.
- R8: The auxiliary line (`ca_line` for A, `cb_line` for B) follows control bit 3 when control bits 5 and 4 are both 1. For any other code it sits at 0.
- R9: A control-register read returns stored bits 5..0. Bits 7 and 6 always read 0 and cannot be written.
- R10: A low `rst_n` sampled on a clock edge clears all direction, output and control registers. After reset every pin is an input, both auxiliary lines are 0, and the shared location reaches the direction register.
- R11: A write to one port leaves every register of the other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 2 | Register select: bit 1 = port, bit 0 = control |
| stb | input | 1 | Enable strobe; writes only while high |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data to the processor |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 8 | Port A pin output enables |
| ca_line | output | 1 | Port A auxiliary control line |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 8 | Port B pin output enables |
| cb_line | output | 1 | Port B auxiliary control line |

## Verification
Directed sequences load a mixed direction pattern (0xF0) and read the data location with pin values that differ from the output register. A wrong per-bit merge then shows up as a wrong nibble. They also toggle control bit 2 between writes, which tells a direction access from an output access.

Each chip-select input is dropped on its own, and the strobe and read/write line are held in their non-write states. This shows which condition gates a write. Control codes 11x and 10x exercise the auxiliary line, and writes to port B are checked against port A to show the ports are isolated. A long random phase then mixes all the fields with occasional resets, and every output is compared against a behavioural model on every cycle.

// File: rtl/dpio_pkg.sv
package dpio_pkg;

   // bit of the control register that routes the shared location
   localparam int unsigned CTL_ROUTE_BIT = 2;
   // lowest bit of the auxiliary-line mode code
   localparam int unsigned AUX_CODE_LSB  = 3;
   localparam int unsigned AUX_CODE_W    = 3;
   // number of control bits that are stored
   localparam int unsigned CTL_KEEP_W    = AUX_CODE_LSB + AUX_CODE_W;
   // register-select width: one port bit, one control bit
   localparam int unsigned RSEL_W        = 2;
   localparam int unsigned PORT_COUNT    = 1 << (RSEL_W - 1);

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_DIR  = 2'd1,
      TGT_OUT  = 2'd2,
      TGT_CTL  = 2'd3
   } tgt_e;

   // auxiliary-line level for a mode code; only the manual code drives
   function automatic logic aux_level(input logic [AUX_CODE_W-1:0] code,
                                      input logic idle);
      if (code[2:1] == 2'b11) return code[0];
      return idle;
   endfunction

endpackage

// File: rtl/dpio_bus_decode.sv
module dpio_bus_decode
   import dpio_pkg::*;
#(
   parameter int unsigned NPORT = PORT_COUNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_a,
   input  logic              cs_b,
   input  logic              cs_n,
   input  logic              rw,
   input  logic [RSEL_W-1:0] rsel,
   input  logic              stb,
   input  logic [NPORT-1:0]  route_bits,
   output logic              rd_act,
   output logic              port_idx,
   output tgt_e              tgt,
   output logic [NPORT-1:0]  wr_dir,
   output logic [NPORT-1:0]  wr_out,
   output logic [NPORT-1:0]  wr_ctl
);

   initial begin
      if (NPORT != 2) $error("dpio_bus_decode: exactly two ports are supported");
   end

   logic chip_sel;
   logic wr_cyc;

   assign chip_sel = cs_a & cs_b & ~cs_n;
   assign wr_cyc   = chip_sel & ~rw & stb;
   assign rd_act   = chip_sel & rw;
   assign port_idx = rsel[1];

   always_comb begin
      if (!chip_sel)            tgt = TGT_NONE;
      else if (rsel[0])         tgt = TGT_CTL;
      else if (route_bits[port_idx]) tgt = TGT_OUT;
      else                      tgt = TGT_DIR;
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_wen
      logic hit;
      assign hit       = wr_cyc && (port_idx == p[0]);
      assign wr_dir[p] = hit && (tgt == TGT_DIR);
      assign wr_out[p] = hit && (tgt == TGT_OUT);
      assign wr_ctl[p] = hit && (tgt == TGT_CTL);
   end

   // R2
   wen_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_dir, wr_out, wr_ctl}));

   // R4
   wen_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb || rw) |-> ({wr_dir, wr_out, wr_ctl} == '0));

endmodule

// File: rtl/dpio_port_bank.sv
module dpio_port_bank
   import dpio_pkg::*;
#(
   parameter int unsigned W        = 8,
   parameter bit          AUX_IDLE = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_dir,
   input  logic                  wr_out,
   input  logic                  wr_ctl,
   input  logic [W-1:0]          wdata,
   input  logic [W-1:0]          pin_in,
   output logic [W-1:0]          dir_q,
   output logic [W-1:0]          out_q,
   output logic [CTL_KEEP_W-1:0] ctl_q,
   output logic [W-1:0]          data_view,
   output logic                  route,
   output logic                  aux
);

   initial begin
      if (W < CTL_KEEP_W) $error("dpio_port_bank: W must hold the control bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
         ctl_q <= '0;
      end else begin
         if (wr_dir) dir_q <= wdata;
         if (wr_out) out_q <= wdata;
         if (wr_ctl) ctl_q <= wdata[CTL_KEEP_W-1:0];
      end
   end

   // per-pin read merge: input pins read live, output pins read the register
   for (genvar b = 0; b < W; b++) begin : g_pin
      assign data_view[b] = dir_q[b] ? out_q[b] : pin_in[b];
   end

   assign route = ctl_q[CTL_ROUTE_BIT];

   // auxiliary line: level set by idle parameter when not in manual mode
   if (AUX_IDLE) begin : g_aux_hi
      assign aux = aux_level(ctl_q[AUX_CODE_LSB +: AUX_CODE_W], 1'b1);
   end else begin : g_aux_lo
      assign aux = aux_level(ctl_q[AUX_CODE_LSB +: AUX_CODE_W], 1'b0);
   end

   // R4
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(dir_q));

   // R4
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_out |=> $stable(out_q));

   // R8
   aux_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctl && $stable(rst_n)) |=> $stable(aux));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (dir_q == '0 && out_q == '0 && ctl_q == '0));

endmodule

// File: rtl/dual_port_pio.sv
module dual_port_pio
   import dpio_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter bit          AUX_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_a,
   input  logic              cs_b,
   input  logic              cs_n,
   input  logic              rw,
   input  logic [RSEL_W-1:0] rsel,
   input  logic              stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   output logic              ca_line,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   output logic              cb_line
);

   localparam int unsigned NP = PORT_COUNT;

   initial begin
      if (DATA_W < CTL_KEEP_W) $error("dual_port_pio: DATA_W too narrow");
   end

   logic                  rd_act;
   logic                  port_idx;
   tgt_e                  tgt;
   logic [NP-1:0]         wr_dir, wr_out, wr_ctl, route, aux;
   logic [DATA_W-1:0]     pin_in  [NP];
   logic [DATA_W-1:0]     dir_q   [NP];
   logic [DATA_W-1:0]     out_q   [NP];
   logic [DATA_W-1:0]     view    [NP];
   logic [CTL_KEEP_W-1:0] ctl_q   [NP];

   dpio_bus_decode #(.NPORT(NP)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_a       (cs_a),
      .cs_b       (cs_b),
      .cs_n       (cs_n),
      .rw         (rw),
      .rsel       (rsel),
      .stb        (stb),
      .route_bits (route),
      .rd_act     (rd_act),
      .port_idx   (port_idx),
      .tgt        (tgt),
      .wr_dir     (wr_dir),
      .wr_out     (wr_out),
      .wr_ctl     (wr_ctl)
   );

   assign pin_in[0] = pa_in;
   assign pin_in[1] = pb_in;

   for (genvar p = 0; p < NP; p++) begin : g_port
      dpio_port_bank #(.W(DATA_W), .AUX_IDLE(AUX_IDLE)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_dir    (wr_dir[p]),
         .wr_out    (wr_out[p]),
         .wr_ctl    (wr_ctl[p]),
         .wdata     (wdata),
         .pin_in    (pin_in[p]),
         .dir_q     (dir_q[p]),
         .out_q     (out_q[p]),
         .ctl_q     (ctl_q[p]),
         .data_view (view[p]),
         .route     (route[p]),
         .aux       (aux[p])
      );
   end

   assign pa_out  = out_q[0];
   assign pa_oe   = dir_q[0];
   assign ca_line = aux[0];
   assign pb_out  = out_q[1];
   assign pb_oe   = dir_q[1];
   assign cb_line = aux[1];

   always_comb begin
      rdata = '0;
      if (rd_act) begin
         unique case (tgt)
            TGT_CTL: rdata = DATA_W'(ctl_q[port_idx]);
            TGT_OUT: rdata = view[port_idx];
            TGT_DIR: rdata = dir_q[port_idx];
            default: rdata = '0;
         endcase
      end
   end

   // R1
   unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs_a && cs_b && !cs_n) |=> ($stable(pa_oe) && $stable(pa_out) &&
                                    $stable(pb_oe) && $stable(pb_out)));

   // R5
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs_a && cs_b && !cs_n && rw) |-> (rdata == '0));

   // R11
   port_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_a && cs_b && !cs_n && !rw && stb && !rsel[1])
         |=> ($stable(pb_oe) && $stable(pb_out) && $stable(cb_line)));

endmodule

// File: tb/dual_port_pio_bench.sv
`timescale 1ns/1ps
module dual_port_pio_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_a = 1'b0, cs_b = 1'b0, cs_n = 1'b1, rw = 1'b1, stb = 1'b0;
   logic [1:0] rsel = 2'b00;
   logic [7:0] wdata = 8'h00, pa_in = 8'h00, pb_in = 8'h00;
   logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe;
   logic       ca_line, cb_line;

   int checks = 0;
   int errors = 0;

   // behavioural model state
   logic [7:0] m_dir [2];
   logic [7:0] m_out [2];
   logic [5:0] m_ctl [2];

   always #4 clk = ~clk;   // 125 MHz

   dual_port_pio u_dual_port_pio (
      .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .cs_n(cs_n),
      .rw(rw), .rsel(rsel), .stb(stb), .wdata(wdata), .rdata(rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .ca_line(ca_line),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .cb_line(cb_line)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_rdata();
      int p;
      logic [7:0] pin;
      if (!(cs_a && cs_b && !cs_n && rw)) return 8'h00;
      p   = rsel[1] ? 1 : 0;
      pin = p ? pb_in : pa_in;
      if (rsel[0]) return {2'b00, m_ctl[p]};
      if (m_ctl[p][2]) return (pin & ~m_dir[p]) | (m_out[p] & m_dir[p]);
      return m_dir[p];
   endfunction

   function automatic logic exp_aux(input int p);
      return (m_ctl[p][5:4] == 2'b11) ? m_ctl[p][3] : 1'b0;
   endfunction

   task automatic compare_all(input string tag);
      chk(tag,        rdata,   exp_rdata());
      chk("R7 pa_out", pa_out, m_out[0]);
      chk("R7 pa_oe",  pa_oe,  m_dir[0]);
      chk("R7 pb_out", pb_out, m_out[1]);
      chk("R7 pb_oe",  pb_oe,  m_dir[1]);
      chk("R8 ca",     {7'd0, ca_line}, {7'd0, exp_aux(0)});
      chk("R8 cb",     {7'd0, cb_line}, {7'd0, exp_aux(1)});
   endtask

   task automatic model_edge();
      int p;
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_dir[i] = '0; m_out[i] = '0; m_ctl[i] = '0;
         end
      end else if (cs_a && cs_b && !cs_n && !rw && stb) begin
         p = rsel[1] ? 1 : 0;
         if (rsel[0])          m_ctl[p] = wdata[5:0];
         else if (m_ctl[p][2]) m_out[p] = wdata;
         else                  m_dir[p] = wdata;
      end
   endtask

   task automatic step(input logic r, input logic c1, input logic c2, input logic cn,
                       input logic w, input logic [1:0] s, input logic st,
                       input logic [7:0] d, input logic [7:0] ia, input logic [7:0] ib,
                       input string tag);
      @(negedge clk);
      rst_n = r; cs_a = c1; cs_b = c2; cs_n = cn; rw = w; rsel = s; stb = st;
      wdata = d; pa_in = ia; pb_in = ib;
      #1;
      compare_all(tag);
      @(posedge clk);
      model_edge();
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d, input string tag);
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, s, 1'b1, d, pa_in, pb_in, tag);
   endtask

   task automatic rd(input logic [1:0] s, input logic [7:0] ia, input logic [7:0] ib,
                     input string tag);
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, s, 1'b0, 8'h00, ia, ib, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_dir[i] = '0; m_out[i] = '0; m_ctl[i] = '0;
      end
      // R10: reset clears everything
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 8'h00, 8'h00, 8'h00, "R10");
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 8'h00, 8'h00, 8'h00, "R10");
      rd(2'b01, 8'h00, 8'h00, "R10 ctl A");
      rd(2'b00, 8'h00, 8'h00, "R10 dir A");
      // R3: direction then output through the shared location
      wr(2'b00, 8'hF0, "R3 dir A");
      rd(2'b00, 8'h3C, 8'h00, "R3 dir readback");
      wr(2'b01, 8'h04, "R2 ctl A");
      wr(2'b00, 8'hA5, "R3 out A");
      rd(2'b00, 8'h3C, 8'h00, "R6 mixed read");
      rd(2'b00, 8'hC3, 8'h00, "R6 mixed read");
      rd(2'b00, 8'h3C, 8'h00, "R7 pins");
      // R1: each select dropped on its own
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8'h11, 8'h00, 8'h00, "R1 cs_a");
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 8'h22, 8'h00, 8'h00, "R1 cs_b");
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 8'h33, 8'h00, 8'h00, "R1 cs_n");
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 8'h00, 8'h00, 8'h00, "R1 unselected read");
      rd(2'b00, 8'h00, 8'h00, "R1 unchanged");
      // R4: no strobe, or read with strobe
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 8'h5A, 8'h00, 8'h00, "R4 no strobe");
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 8'h5A, 8'h00, 8'h00, "R4 read strobe");
      rd(2'b00, 8'h00, 8'h00, "R4 unchanged");
      // R8: auxiliary line codes
      wr(2'b01, 8'h3C, "R8 manual set");
      rd(2'b01, 8'h00, 8'h00, "R8 ctl read");
      wr(2'b01, 8'h34, "R8 manual clear");
      wr(2'b01, 8'h2C, "R8 other code");
      rd(2'b01, 8'h00, 8'h00, "R8 idle");
      // R9: upper control bits read zero
      wr(2'b01, 8'hFF, "R9 ctl all ones");
      rd(2'b01, 8'h00, 8'h00, "R9 readback");
      // R11: port B activity leaves A alone
      wr(2'b10, 8'h0F, "R11 dir B");
      wr(2'b11, 8'h3C, "R11 ctl B");
      wr(2'b10, 8'h96, "R11 out B");
      rd(2'b10, 8'h00, 8'hF0, "R11 data B");
      rd(2'b00, 8'hAA, 8'h00, "R11 port A intact");
      rd(2'b01, 8'h00, 8'h00, "R11 ctl A intact");
      // R10: reset after activity
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 8'h00, 8'h00, 8'h00, "R10 mid reset");
      rd(2'b11, 8'h00, 8'h00, "R10 after reset");
      // R5: random mixed traffic
      for (int n = 0; n < 4000; n++) begin
         step(($urandom_range(0, 99) != 0), ($urandom_range(0, 7) != 0),
              ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0),
              1'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), "R5 random");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule